// File: doc/BRIEF.md
# Dispatch Group Slot Checker

This block follows how a superscalar front end packs instructions into fixed-size dispatch groups of five slots. Up to four of the slots take non-branch work and the last one takes only a branch. Each cycle the scheduler presents one candidate instruction. The candidate carries an execution-unit class and a few flags: first-only, whole-group, cracked, count-register write, branch through the count register, load and store. The block answers at once with a 2-bit verdict. The verdict says the candidate may join the current group, must stall until a new group opens, or needs a filler no-op to get past a costly pipeline hazard.

A commit strobe tells the block that the presented candidate was actually dispatched, and the block then updates its slot count and hazard state. An idle strobe burns one slot for a cycle with no dispatch. When the slot count reaches five, a new group begins and all per-group state is cleared. Address overlap between a load and earlier stores is worked out outside this block and arrives as a single bit. That bit matters only while the current group holds at least one committed store.

Top module: `dispatch_slot_checker`

## Requirements
- R1: After reset `slots_used` is 0, and `verdict` is 2'b00 whenever `cand_valid` is low. Verdict codes are 2'b00 none, 2'b01 stall and 2'b10 insert no-op.
- R2: A candidate with `cand_first_only` or `cand_whole_group` set gets stall when `slots_used` is not 0, and gets none when `slots_used` is 0.
- R3: A candidate with `cand_cracked` set gets stall when `slots_used` is above 2. A committed cracked candidate adds 2 to `slots_used`.
- R4: Unit classes 1 (fixed), 2 (load/store), 3 (float), 4 (vector ALU) and 5 (vector permute) get stall when `slots_used` is 4. A branch (class 7) at `slots_used` 4 gets none.
- R5: Condition-register class (6) gets stall when `slots_used` is 2 or more, and gets none below that.
- R6: Committing a branch or a whole-group candidate closes the group, so `slots_used` is 0 on the next cycle. Any other committed non-pseudo candidate adds 1.
- R7: An idle strobe without commit adds 1 to `slots_used`. Reaching five slots returns `slots_used` to 0 and clears the count-register-set flag and the store count.
- R8: A pseudo candidate (class 0) always gets none, and committing it leaves `slots_used` unchanged.
- R9: After a candidate with `cand_writes_ctr` has been committed in the current group, a candidate with `cand_branch_via_ctr` gets insert no-op.
- R10: A load candidate with `mem_overlap` high gets insert no-op only when at least one store has been committed in the current group. Otherwise it gets none.
- R11: Any stall condition takes precedence over an insert no-op condition.
- R12: When commit and idle are asserted in the same cycle, only the commit updates the state and the idle strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | Candidate instruction present |
| cand_unit | input | 3 | Unit class: 0 pseudo, 1 fixed, 2 load/store, 3 float, 4 vector ALU, 5 vector permute, 6 condition register, 7 branch |
| cand_first_only | input | 1 | Candidate must start a group |
| cand_whole_group | input | 1 | Candidate occupies a group alone |
| cand_cracked | input | 1 | Candidate splits into two micro-ops |
| cand_writes_ctr | input | 1 | Candidate writes the count register |
| cand_branch_via_ctr | input | 1 | Candidate branches through the count register |
| cand_is_load | input | 1 | Candidate reads memory |
| cand_is_store | input | 1 | Candidate writes memory |
| mem_overlap | input | 1 | External flag: the load overlaps an earlier store |
| commit | input | 1 | Presented candidate is dispatched this cycle |
| idle_tick | input | 1 | Consume one slot without dispatch |
| verdict | output | 2 | Hazard verdict for the candidate |
| slots_used | output | 3 | Slots used in the current group |

## Verification
`verdict` is combinational. It is due in the same cycle that the candidate inputs change, so the bench drives on the falling edge and samples one nanosecond later, with no clock edge in between. `slots_used` and the hidden count-register and store state change on the rising edge that samples a commit or idle strobe. The bench samples them at the following falling edge, and it probes the hidden state through a later candidate's verdict in that same half cycle. Each scenario task counts every commit and idle strobe it issues, so the expected slot count is known before each sample.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    UC_PSEUDO = 3'd0,
    UC_FIXED  = 3'd1,
    UC_LDST   = 3'd2,
    UC_FLOAT  = 3'd3,
    UC_VALU   = 3'd4,
    UC_VPERM  = 3'd5,
    UC_CREG   = 3'd6,
    UC_BRANCH = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    VD_NONE  = 2'd0,
    VD_STALL = 2'd1,
    VD_NOOP  = 2'd2
  } verdict_e;

  typedef struct packed {
    unit_e unit;
    logic  first_only;
    logic  whole_group;
    logic  cracked;
    logic  writes_ctr;
    logic  branch_via_ctr;
    logic  is_load;
    logic  is_store;
  } cand_t;

  function automatic logic is_plain_unit(unit_e u);
    return (u == UC_FIXED) || (u == UC_LDST) || (u == UC_FLOAT) ||
           (u == UC_VALU) || (u == UC_VPERM);
  endfunction

endpackage

// File: rtl/dsc_slot_rules.sv
module dsc_slot_rules
  import dsc_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_SLOTS    = 2,
  parameter int CRACK_LIMIT = 2,
  parameter int CNT_W       = 3
) (
  input  logic             cand_valid,
  input  cand_t            cand,
  input  logic [CNT_W-1:0] slots_q,
  input  logic             ctr_set_q,
  input  logic             stores_nz,
  input  logic             mem_overlap,
  output verdict_e         verdict
);

  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(GROUP_SLOTS - 1);
  localparam logic [CNT_W-1:0] CR_LIM    = CNT_W'(CR_SLOTS);
  localparam logic [CNT_W-1:0] CRK_LIM   = CNT_W'(CRACK_LIMIT);

  logic group_fresh;
  logic stall_first;
  logic stall_crack;
  logic stall_plain;
  logic stall_creg;
  logic any_stall;
  logic noop_ctr;
  logic noop_mem;

  always_comb begin
    group_fresh = (slots_q == '0);
    stall_first = (cand.first_only || cand.whole_group) && !group_fresh;
    stall_crack = cand.cracked && (slots_q > CRK_LIM);
    stall_plain = is_plain_unit(cand.unit) && (slots_q == LAST_SLOT);
    stall_creg  = (cand.unit == UC_CREG) && (slots_q >= CR_LIM);
    any_stall   = stall_first | stall_crack | stall_plain | stall_creg;
    noop_ctr    = ctr_set_q && cand.branch_via_ctr;
    noop_mem    = cand.is_load && stores_nz && mem_overlap;
  end

  always_comb begin
    verdict = VD_NONE;
    if (cand_valid && (cand.unit != UC_PSEUDO)) begin
      if (any_stall)                 verdict = VD_STALL;
      else if (noop_ctr || noop_mem) verdict = VD_NOOP;
    end
  end

endmodule

// File: rtl/dsc_group_state.sv
module dsc_group_state
  import dsc_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int MAX_STORES  = 8,
  parameter int CNT_W       = 3,
  parameter int ST_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_valid,
  input  cand_t            cand,
  input  logic             commit,
  input  logic             idle_tick,
  output logic [CNT_W-1:0] slots_q,
  output logic             ctr_set_q,
  output logic             stores_nz
);

  localparam logic [CNT_W:0]  FULL_W = (CNT_W+1)'(GROUP_SLOTS);
  localparam logic [ST_W-1:0] ST_MAX = ST_W'(MAX_STORES);

  logic [ST_W-1:0]  stores_q, stores_d;
  logic [CNT_W-1:0] slots_d;
  logic             ctr_set_d;
  logic [CNT_W:0]   sum;
  logic             take_commit;
  logic             closes;
  logic             state_en;

  always_comb begin
    take_commit = commit && cand_valid && (cand.unit != UC_PSEUDO);
    closes      = (cand.unit == UC_BRANCH) || cand.whole_group;
    state_en    = take_commit || idle_tick;
  end

  always_comb begin
    slots_d   = slots_q;
    ctr_set_d = ctr_set_q;
    stores_d  = stores_q;
    sum       = '0;
    if (take_commit) begin
      if (cand.writes_ctr) ctr_set_d = 1'b1;
      if (cand.is_store && (stores_q != ST_MAX)) stores_d = stores_q + ST_W'(1);
      if (closes) sum = FULL_W;
      else        sum = {1'b0, slots_q} + (CNT_W+1)'(1) + {{CNT_W{1'b0}}, cand.cracked};
    end else if (idle_tick) begin
      sum = {1'b0, slots_q} + (CNT_W+1)'(1);
    end
    if (state_en) begin
      if (sum >= FULL_W) begin
        slots_d   = '0;
        ctr_set_d = 1'b0;
        stores_d  = '0;
      end else begin
        slots_d = sum[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q   <= '0;
      ctr_set_q <= 1'b0;
      stores_q  <= '0;
    end else if (state_en) begin
      slots_q   <= slots_d;
      ctr_set_q <= ctr_set_d;
      stores_q  <= stores_d;
    end
  end

  assign stores_nz = (stores_q != '0);

endmodule

// File: rtl/dispatch_slot_checker.sv
module dispatch_slot_checker
  import dsc_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_SLOTS    = 2,
  parameter int CRACK_LIMIT = 2,
  parameter int MAX_STORES  = 8,
  localparam int CNT_W      = $clog2(GROUP_SLOTS + 1),
  localparam int ST_W       = $clog2(MAX_STORES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_valid,
  input  logic [2:0]       cand_unit,
  input  logic             cand_first_only,
  input  logic             cand_whole_group,
  input  logic             cand_cracked,
  input  logic             cand_writes_ctr,
  input  logic             cand_branch_via_ctr,
  input  logic             cand_is_load,
  input  logic             cand_is_store,
  input  logic             mem_overlap,
  input  logic             commit,
  input  logic             idle_tick,
  output logic [1:0]       verdict,
  output logic [CNT_W-1:0] slots_used
);

  cand_t            cand;
  verdict_e         vd;
  logic [CNT_W-1:0] slots_q;
  logic             ctr_set_q;
  logic             stores_nz;

  always_comb begin
    cand.unit           = unit_e'(cand_unit);
    cand.first_only     = cand_first_only;
    cand.whole_group    = cand_whole_group;
    cand.cracked        = cand_cracked;
    cand.writes_ctr     = cand_writes_ctr;
    cand.branch_via_ctr = cand_branch_via_ctr;
    cand.is_load        = cand_is_load;
    cand.is_store       = cand_is_store;
  end

  dsc_group_state #(
    .GROUP_SLOTS(GROUP_SLOTS), .MAX_STORES(MAX_STORES),
    .CNT_W(CNT_W), .ST_W(ST_W)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand(cand),
    .commit(commit), .idle_tick(idle_tick),
    .slots_q(slots_q), .ctr_set_q(ctr_set_q), .stores_nz(stores_nz)
  );

  dsc_slot_rules #(
    .GROUP_SLOTS(GROUP_SLOTS), .CR_SLOTS(CR_SLOTS),
    .CRACK_LIMIT(CRACK_LIMIT), .CNT_W(CNT_W)
  ) u_rules (
    .cand_valid(cand_valid), .cand(cand), .slots_q(slots_q),
    .ctr_set_q(ctr_set_q), .stores_nz(stores_nz),
    .mem_overlap(mem_overlap), .verdict(vd)
  );

  assign verdict    = vd;
  assign slots_used = slots_q;

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int GROUP_SLOTS = 5,
  parameter int CNT_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cand_valid,
  input logic [2:0]       cand_unit,
  input logic             cand_first_only,
  input logic             cand_whole_group,
  input logic             commit,
  input logic             idle_tick,
  input logic [1:0]       verdict,
  input logic [CNT_W-1:0] slots_used
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP_SLOTS - 1);

  // R7: the count never rests at a full group, so an idle strobe is never seen at five
  a_r7_no_full_rest: assert property (@(posedge clk) disable iff (!rst_n)
    slots_used <= LAST);

  a_r1_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_valid |-> verdict == 2'b00);

  a_r2_first_only_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_unit != 3'd0 && (cand_first_only || cand_whole_group) &&
     slots_used != '0) |-> verdict == 2'b01);

  a_r8_pseudo_none: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_unit == 3'd0) |-> verdict == 2'b00);

  a_r6_branch_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cand_valid && cand_unit == 3'd7) |=> slots_used == '0);

  a_r7_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_tick && !commit && slots_used != LAST) |=>
      slots_used == $past(slots_used) + CNT_W'(1));

endmodule

bind dispatch_slot_checker dsc_checker #(
  .GROUP_SLOTS(GROUP_SLOTS), .CNT_W(CNT_W)
) u_dsc_checker (
  .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_unit(cand_unit),
  .cand_first_only(cand_first_only), .cand_whole_group(cand_whole_group),
  .commit(commit), .idle_tick(idle_tick), .verdict(verdict),
  .slots_used(slots_used)
);

// File: tb/dispatch_slot_checker_bench.sv
module dispatch_slot_checker_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cand_valid, cand_first_only, cand_whole_group, cand_cracked;
  logic       cand_writes_ctr, cand_branch_via_ctr, cand_is_load, cand_is_store;
  logic       mem_overlap, commit, idle_tick;
  logic [2:0] cand_unit;
  logic [1:0] verdict;
  logic [2:0] slots_used;

  int vectors = 0;
  int fails   = 0;

  localparam logic [1:0] NONE = 2'b00, STALL = 2'b01, NOOP = 2'b10;

  always #5 clk = ~clk;

  dispatch_slot_checker u_dispatch_slot_checker (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_unit(cand_unit),
    .cand_first_only(cand_first_only), .cand_whole_group(cand_whole_group),
    .cand_cracked(cand_cracked), .cand_writes_ctr(cand_writes_ctr),
    .cand_branch_via_ctr(cand_branch_via_ctr), .cand_is_load(cand_is_load),
    .cand_is_store(cand_is_store), .mem_overlap(mem_overlap),
    .commit(commit), .idle_tick(idle_tick), .verdict(verdict),
    .slots_used(slots_used)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive a candidate on the falling edge; flags: first,whole,cracked,wctr,bctr,load,store
  task automatic cand(logic [2:0] u, logic [6:0] f, logic ov);
    @(negedge clk);
    cand_valid = 1'b1; cand_unit = u;
    {cand_first_only, cand_whole_group, cand_cracked, cand_writes_ctr,
     cand_branch_via_ctr, cand_is_load, cand_is_store} = f;
    mem_overlap = ov;
    #1;
  endtask

  task automatic clear_cand();
    @(negedge clk);
    cand_valid = 1'b0; cand_unit = 3'd0;
    {cand_first_only, cand_whole_group, cand_cracked, cand_writes_ctr,
     cand_branch_via_ctr, cand_is_load, cand_is_store} = '0;
    mem_overlap = 1'b0;
    #1;
  endtask

  // commit the candidate now presented, optionally with idle in the same cycle
  task automatic strobe(logic c, logic i);
    commit = c; idle_tick = i;
    @(posedge clk);
    @(negedge clk);
    commit = 1'b0; idle_tick = 1'b0;
    #1;
  endtask

  task automatic commit_unit(logic [2:0] u, logic [6:0] f);
    cand(u, f, 1'b0);
    strobe(1'b1, 1'b0);
  endtask

  task automatic idles(int n);
    clear_cand();
    for (int k = 0; k < n; k++) strobe(1'b0, 1'b1);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset slots", slots_used, 0);
    chk("R1 verdict idle", verdict, NONE);
  endtask

  task automatic t_plain_fill();
    for (int k = 0; k < 4; k++) commit_unit(3'd1 + 3'(k), 7'b0);
    chk("R6 four singles", slots_used, 4);
    for (int u = 1; u <= 5; u++) begin
      cand(3'(u), 7'b0, 1'b0);
      chk("R4 plain class at slot 4", verdict, STALL);
    end
    cand(3'd7, 7'b0, 1'b0);
    chk("R4 branch at slot 4", verdict, NONE);
    strobe(1'b1, 1'b0);
    chk("R6 branch closes", slots_used, 0);
  endtask

  task automatic t_first_whole();
    cand(3'd1, 7'b1000000, 1'b0);
    chk("R2 first-only at 0", verdict, NONE);
    commit_unit(3'd1, 7'b0);
    cand(3'd1, 7'b1000000, 1'b0);
    chk("R2 first-only at 1", verdict, STALL);
    cand(3'd1, 7'b0100000, 1'b0);
    chk("R2 whole-group at 1", verdict, STALL);
    commit_unit(3'd1, 7'b0);
    commit_unit(3'd1, 7'b0);
    idles(2);
    chk("R7 idle closes", slots_used, 0);
    cand(3'd1, 7'b0100000, 1'b0);
    chk("R2 whole-group at 0", verdict, NONE);
    strobe(1'b1, 1'b0);
    chk("R6 whole-group closes", slots_used, 0);
  endtask

  task automatic t_cracked();
    commit_unit(3'd1, 7'b0);
    commit_unit(3'd1, 7'b0);
    cand(3'd2, 7'b0010000, 1'b0);
    chk("R3 cracked at 2", verdict, NONE);
    strobe(1'b1, 1'b0);
    chk("R3 cracked adds two", slots_used, 4);
    idles(1);
    chk("R7 idle wraps", slots_used, 0);
    for (int k = 0; k < 3; k++) commit_unit(3'd1, 7'b0);
    cand(3'd2, 7'b0010000, 1'b0);
    chk("R3 cracked at 3", verdict, STALL);
    idles(2);
  endtask

  task automatic t_creg();
    cand(3'd6, 7'b0, 1'b0);
    chk("R5 cr at 0", verdict, NONE);
    commit_unit(3'd1, 7'b0);
    cand(3'd6, 7'b0, 1'b0);
    chk("R5 cr at 1", verdict, NONE);
    strobe(1'b1, 1'b0);
    cand(3'd6, 7'b0, 1'b0);
    chk("R5 cr at 2", verdict, STALL);
    idles(3);
    chk("R5 group reset", slots_used, 0);
  endtask

  task automatic t_ctr();
    cand(3'd7, 7'b0000100, 1'b0);
    chk("R9 no ctr write", verdict, NONE);
    commit_unit(3'd1, 7'b0001000);
    cand(3'd7, 7'b0000100, 1'b0);
    chk("R9 branch via ctr", verdict, NOOP);
    idles(4);
    cand(3'd7, 7'b0000100, 1'b0);
    chk("R7 ctr flag cleared", verdict, NONE);
  endtask

  task automatic t_overlap();
    cand(3'd2, 7'b0000010, 1'b1);
    chk("R10 overlap no store", verdict, NONE);
    commit_unit(3'd2, 7'b0000001);
    cand(3'd2, 7'b0000010, 1'b1);
    chk("R10 overlap after store", verdict, NOOP);
    cand(3'd2, 7'b0000010, 1'b0);
    chk("R10 no overlap", verdict, NONE);
    commit_unit(3'd1, 7'b0);
    commit_unit(3'd1, 7'b0);
    commit_unit(3'd1, 7'b0);
    cand(3'd2, 7'b0000010, 1'b1);
    chk("R11 stall beats noop", verdict, STALL);
    idles(1);
    cand(3'd2, 7'b0000010, 1'b1);
    chk("R7 stores cleared", verdict, NONE);
  endtask

  task automatic t_pseudo_and_priority();
    cand(3'd0, 7'b1100000, 1'b1);
    chk("R8 pseudo verdict", verdict, NONE);
    strobe(1'b1, 1'b0);
    chk("R8 pseudo no slot", slots_used, 0);
    cand(3'd1, 7'b0, 1'b0);
    strobe(1'b1, 1'b1);
    chk("R12 idle ignored with commit", slots_used, 1);
    idles(4);
    chk("R12 group end", slots_used, 0);
  endtask

  initial begin
    rst_n = 1'b0; commit = 1'b0; idle_tick = 1'b0;
    cand_valid = 1'b0; cand_unit = 3'd0; mem_overlap = 1'b0;
    {cand_first_only, cand_whole_group, cand_cracked, cand_writes_ctr,
     cand_branch_via_ctr, cand_is_load, cand_is_store} = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain_fill();
    t_first_whole();
    t_cracked();
    t_creg();
    t_ctr();
    t_overlap();
    t_pseudo_and_priority();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule